// File: doc/BRIEF.md
# Branch Target Selection Controller

This block turns the lookup results gathered for one fetched control-flow instruction into a single next-fetch prediction. It takes these inputs:
- the instruction's class bits;
- the direction predictor's verdict;
- the hit flag and target from the branch target buffer;
- the hit flag and target from the indirect target predictor;
- the top and empty flag of the return-address stack;
- the instruction address.

From these it decides whether the instruction is predicted taken, and it chooses the next fetch address. It also issues push and pop commands to the return-address stack and produces the flags the front end keeps in its speculation history for later repair.

When a target source misses, a taken direction is overridden to not taken. When a conditional call misses its target, the push it would have made is withdrawn within the same prediction. Then the stack is left untouched, and the history no longer claims a push. The fall-through address is the instruction address plus four, and all addresses are 32 bits wide.

A small state machine times the outputs. Its states are ST_IDLE (no result held) and ST_EMIT (a result is presented). It has four transitions:
- TR_START: ST_IDLE to ST_EMIT on a valid input.
- TR_STREAM: ST_EMIT to ST_EMIT on a valid input.
- TR_DRAIN: ST_EMIT to ST_IDLE with no input.
- TR_REST: ST_IDLE to ST_IDLE with no input.

Top module: `bts_ctrl`

## Requirements
- R1: After reset, out_valid is 0 and every command and flag output is 0.
- R2: A prediction appears on the outputs in the cycle after in_valid was 1. out_valid is 1 exactly in the cycles that follow a cycle with in_valid 1. In any cycle after one with in_valid 0, every command and flag output is 0.
- R3: The direction is taken when is_uncond is 1, and otherwise equals dir_taken. When the direction is not taken:
  - out_taken is 0 and out_next_pc is in_pc+4;
  - no push or pop is issued;
  - out_was_return equals is_return.
- R4: A return (is_return 1, which takes priority over is_call) with a taken direction and a non-empty stack is predicted taken. It targets stk_top+4, pops the stack, and sets out_used_stack and out_was_return.
- R5: A return with a taken direction and stk_empty 1 is predicted not taken. It targets in_pc+4, sets out_was_return and does not pop.
- R6: A non-return call with a taken direction raises out_push, with out_push_pc equal to in_pc, and sets out_was_call and out_pushed.
- R7: A taken non-return uses the target buffer when is_direct is 1 or ind_enable is 0. On btb_hit it is predicted taken to btb_target.
- R8: On a target-buffer miss the prediction is not taken with target in_pc+4. out_dir_fix is raised only when the instruction is not a call.
- R9: A call that is conditional (is_uncond 0) and misses its target source has its push withdrawn: out_push and out_pushed are 0, while out_was_call stays 1. An unconditional call that misses keeps its push.
- R10: A taken non-return with is_direct 0 and ind_enable 1 sets out_was_indirect. An ind_hit gives taken to ind_target. A miss gives not taken to in_pc+4 without out_dir_fix.
- R11: out_push and out_pop are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup results are presented this cycle |
| in_pc | input | 32 | Address of the control instruction |
| is_uncond | input | 1 | Instruction is unconditional |
| is_call | input | 1 | Instruction is a call |
| is_return | input | 1 | Instruction is a return |
| is_direct | input | 1 | Target is encoded in the instruction (0 means indirect) |
| dir_taken | input | 1 | Direction predictor verdict |
| btb_hit | input | 1 | Target buffer holds an entry |
| btb_target | input | 32 | Target buffer address |
| ind_enable | input | 1 | Indirect prediction in use |
| ind_hit | input | 1 | Indirect predictor holds a target |
| ind_target | input | 32 | Indirect predictor address |
| stk_top | input | 32 | Call address on top of the return stack |
| stk_empty | input | 1 | Return stack holds nothing |
| out_valid | output | 1 | Prediction valid |
| out_taken | output | 1 | Final taken verdict |
| out_next_pc | output | 32 | Next fetch address |
| out_push | output | 1 | Push command to the return stack |
| out_push_pc | output | 32 | Address to push |
| out_pop | output | 1 | Pop command to the return stack |
| out_used_stack | output | 1 | History flag: target came from the stack |
| out_was_return | output | 1 | History flag: instruction is a return |
| out_was_call | output | 1 | History flag: instruction is a call |
| out_pushed | output | 1 | History flag: a push is in effect |
| out_was_indirect | output | 1 | History flag: indirect predictor consulted |
| out_dir_fix | output | 1 | Direction predictor must be corrected |

## Verification
A wrong routing decision shows in the cycle after the input as a mismatch among the taken bit, the next address and the stack commands. A wrong history flag shows in that same cycle. An error in the withdrawal of a push would appear as a stray out_push with a not-taken verdict, or as out_pushed without a push. Either would leave the stack one entry deep too far by the next prediction. A state machine stuck in ST_EMIT or ST_IDLE shows within one cycle as out_valid disagreeing with the previous in_valid, or as command outputs left high after an idle cycle.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        SRC_FALL = 2'd0,
        SRC_STACK = 2'd1,
        SRC_BTB = 2'd2,
        SRC_IND = 2'd3
    } src_e;

    typedef struct packed {
        logic taken;
        src_e src;
        logic push;
        logic pop;
        logic used_stack;
        logic was_return;
        logic was_call;
        logic pushed;
        logic was_indirect;
        logic dir_fix;
    } verdict_t;

    localparam verdict_t VERDICT_NONE = '{
        taken: 1'b0, src: SRC_FALL, push: 1'b0, pop: 1'b0,
        used_stack: 1'b0, was_return: 1'b0, was_call: 1'b0,
        pushed: 1'b0, was_indirect: 1'b0, dir_fix: 1'b0
    };

endpackage

// File: rtl/bts_route.sv
// Decides taken verdict, target source, stack commands and history flags.
module bts_route
    import bts_pkg::*;
(
    input  logic     is_uncond,
    input  logic     is_call,
    input  logic     is_return,
    input  logic     is_direct,
    input  logic     dir_taken,
    input  logic     btb_hit,
    input  logic     ind_enable,
    input  logic     ind_hit,
    input  logic     stk_empty,
    output verdict_t verdict
);

    logic want_taken;
    logic use_btb;
    logic retract;

    assign want_taken = is_uncond | dir_taken;
    assign use_btb    = is_direct | ~ind_enable;
    assign retract    = is_call & ~is_uncond;

    always_comb begin
        verdict = VERDICT_NONE;
        if (!want_taken) begin
            verdict.was_return = is_return;
        end else if (is_return) begin
            verdict.was_return = 1'b1;
            if (!stk_empty) begin
                verdict.taken      = 1'b1;
                verdict.src        = SRC_STACK;
                verdict.pop        = 1'b1;
                verdict.used_stack = 1'b1;
            end
        end else begin
            verdict.push     = is_call;
            verdict.was_call = is_call;
            verdict.pushed   = is_call;
            if (use_btb) begin
                if (btb_hit) begin
                    verdict.taken = 1'b1;
                    verdict.src   = SRC_BTB;
                end else if (!is_call) begin
                    verdict.dir_fix = 1'b1;
                end else if (retract) begin
                    verdict.push   = 1'b0;
                    verdict.pushed = 1'b0;
                end
            end else begin
                verdict.was_indirect = 1'b1;
                if (ind_hit) begin
                    verdict.taken = 1'b1;
                    verdict.src   = SRC_IND;
                end else if (retract) begin
                    verdict.push   = 1'b0;
                    verdict.pushed = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/bts_target.sv
// Forms the next fetch address from the selected source.
module bts_target
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  src_e              src,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic [ADDR_W-1:0] ind_target,
    input  logic [ADDR_W-1:0] stk_top,
    output logic [ADDR_W-1:0] next_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    always_comb begin
        unique case (src)
            SRC_STACK: next_pc = stk_top + STEP;
            SRC_BTB:   next_pc = btb_target;
            SRC_IND:   next_pc = ind_target;
            default:   next_pc = pc + STEP;
        endcase
    end

endmodule

// File: rtl/bts_ctrl.sv
// Top: registers one prediction per valid lookup, timed by a two-state FSM.
module bts_ctrl
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic              is_uncond,
    input  logic              is_call,
    input  logic              is_return,
    input  logic              is_direct,
    input  logic              dir_taken,
    input  logic              btb_hit,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic              ind_enable,
    input  logic              ind_hit,
    input  logic [ADDR_W-1:0] ind_target,
    input  logic [ADDR_W-1:0] stk_top,
    input  logic              stk_empty,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc,
    output logic              out_push,
    output logic [ADDR_W-1:0] out_push_pc,
    output logic              out_pop,
    output logic              out_used_stack,
    output logic              out_was_return,
    output logic              out_was_call,
    output logic              out_pushed,
    output logic              out_was_indirect,
    output logic              out_dir_fix
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    state_e state_q, state_d;
    verdict_t verdict, verdict_q;
    logic [ADDR_W-1:0] next_pc, next_pc_q, push_pc_q;

    bts_route u_route (
        .is_uncond (is_uncond),
        .is_call   (is_call),
        .is_return (is_return),
        .is_direct (is_direct),
        .dir_taken (dir_taken),
        .btb_hit   (btb_hit),
        .ind_enable(ind_enable),
        .ind_hit   (ind_hit),
        .stk_empty (stk_empty),
        .verdict   (verdict)
    );

    bts_target #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_target (
        .src       (verdict.src),
        .pc        (in_pc),
        .btb_target(btb_target),
        .ind_target(ind_target),
        .stk_top   (stk_top),
        .next_pc   (next_pc)
    );

    // Transitions: TR_START, TR_STREAM, TR_DRAIN, TR_REST
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            verdict_q <= VERDICT_NONE;
            next_pc_q <= '0;
            push_pc_q <= '0;
        end else begin
            verdict_q <= verdict;
            next_pc_q <= next_pc;
            push_pc_q <= in_pc;
        end
    end

    assign out_valid        = (state_q == ST_EMIT);
    assign out_taken        = verdict_q.taken;
    assign out_next_pc      = next_pc_q;
    assign out_push         = verdict_q.push;
    assign out_push_pc      = push_pc_q;
    assign out_pop          = verdict_q.pop;
    assign out_used_stack   = verdict_q.used_stack;
    assign out_was_return   = verdict_q.was_return;
    assign out_was_call     = verdict_q.was_call;
    assign out_pushed       = verdict_q.pushed;
    assign out_was_indirect = verdict_q.was_indirect;
    assign out_dir_fix      = verdict_q.dir_fix;

endmodule

// File: rtl/bts_ctrl_chk.sv
module bts_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_pc,
    input logic [ADDR_W-1:0] ind_target,
    input logic [ADDR_W-1:0] stk_top,
    input logic              out_valid,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_next_pc,
    input logic              out_push,
    input logic [ADDR_W-1:0] out_push_pc,
    input logic              out_pop,
    input logic              out_used_stack,
    input logic              out_was_call,
    input logic              out_pushed,
    input logic              out_was_indirect,
    input logic              out_dir_fix
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_push && !out_pop));

    // R11
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_push && out_pop));

    // R3
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_taken || out_next_pc == $past(in_pc) + ADDR_W'(4)));

    // R4
    pop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_pop || (out_taken && out_used_stack
                                   && out_next_pc == $past(stk_top) + ADDR_W'(4))));

    // R6
    pushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_pushed || (out_push && out_was_call
                                      && out_push_pc == $past(in_pc))));

    // R8
    dir_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dir_fix |-> (!out_taken && !out_was_call));

    // R10
    ind_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!(out_taken && out_was_indirect)
                      || out_next_pc == $past(ind_target)));

endmodule

bind bts_ctrl bts_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_pc           (in_pc),
    .ind_target      (ind_target),
    .stk_top         (stk_top),
    .out_valid       (out_valid),
    .out_taken       (out_taken),
    .out_next_pc     (out_next_pc),
    .out_push        (out_push),
    .out_push_pc     (out_push_pc),
    .out_pop         (out_pop),
    .out_used_stack  (out_used_stack),
    .out_was_call    (out_was_call),
    .out_pushed      (out_pushed),
    .out_was_indirect(out_was_indirect),
    .out_dir_fix     (out_dir_fix)
);

// File: tb/bts_ctrl_test.sv
module bts_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pc = '0;
    logic        is_uncond = 1'b0, is_call = 1'b0, is_return = 1'b0, is_direct = 1'b0;
    logic        dir_taken = 1'b0, btb_hit = 1'b0, ind_enable = 1'b0, ind_hit = 1'b0;
    logic [31:0] btb_target = '0, ind_target = '0, stk_top = '0;
    logic        stk_empty = 1'b0;
    logic        out_valid, out_taken, out_push, out_pop;
    logic [31:0] out_next_pc, out_push_pc;
    logic        out_used_stack, out_was_return, out_was_call, out_pushed;
    logic        out_was_indirect, out_dir_fix;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bts_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .is_uncond(is_uncond), .is_call(is_call), .is_return(is_return),
        .is_direct(is_direct), .dir_taken(dir_taken), .btb_hit(btb_hit),
        .btb_target(btb_target), .ind_enable(ind_enable), .ind_hit(ind_hit),
        .ind_target(ind_target), .stk_top(stk_top), .stk_empty(stk_empty),
        .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
        .out_push(out_push), .out_push_pc(out_push_pc), .out_pop(out_pop),
        .out_used_stack(out_used_stack), .out_was_return(out_was_return),
        .out_was_call(out_was_call), .out_pushed(out_pushed),
        .out_was_indirect(out_was_indirect), .out_dir_fix(out_dir_fix)
    );

    // expected values for the vector in flight
    logic        e_taken, e_push, e_pop, e_used, e_ret, e_call, e_pushed, e_ind, e_fix;
    logic [31:0] e_next, e_push_pc;
    string       e_rule;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model();
        logic dir;
        dir = is_uncond | dir_taken;
        e_taken = 0; e_push = 0; e_pop = 0; e_used = 0; e_ret = 0;
        e_call = 0; e_pushed = 0; e_ind = 0; e_fix = 0;
        e_next = in_pc + 32'd4;
        e_push_pc = in_pc;
        if (!dir) begin
            e_rule = "R3";
            e_ret = is_return;
        end else if (is_return) begin
            e_ret = 1;
            if (stk_empty) e_rule = "R5";
            else begin
                e_rule = "R4";
                e_taken = 1; e_next = stk_top + 32'd4; e_pop = 1; e_used = 1;
            end
        end else begin
            e_rule = "R7";
            if (is_call) begin
                e_push = 1; e_call = 1; e_pushed = 1; e_rule = "R6";
            end
            if (is_direct || !ind_enable) begin
                if (btb_hit) begin
                    e_taken = 1; e_next = btb_target;
                end else begin
                    e_rule = "R8";
                    if (!is_call) e_fix = 1;
                    else if (!is_uncond) begin
                        e_push = 0; e_pushed = 0; e_rule = "R9";
                    end
                end
            end else begin
                e_ind = 1; e_rule = "R10";
                if (ind_hit) begin
                    e_taken = 1; e_next = ind_target;
                end else if (is_call && !is_uncond) begin
                    e_push = 0; e_pushed = 0; e_rule = "R9";
                end
            end
        end
    endtask

    task automatic compare();
        string tag;
        tag = e_rule;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " taken/next"}, {31'd0, out_taken, out_next_pc}, {31'd0, e_taken, e_next});
        check({tag, " stack cmds"}, {62'd0, out_push, out_pop}, {62'd0, e_push, e_pop});
        if (e_push) check({tag, " push pc"}, 64'(out_push_pc), 64'(e_push_pc));
        check({tag, " flags"},
              {58'd0, out_used_stack, out_was_return, out_was_call, out_pushed, out_was_indirect, out_dir_fix},
              {58'd0, e_used, e_ret, e_call, e_pushed, e_ind, e_fix});
        // R11: never push and pop together
        check("R11 excl", 64'(out_push & out_pop), 64'd0);
    endtask

    initial begin
        #(10 * 5000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {52'd0, out_valid, out_taken, out_push, out_pop, out_used_stack,
              out_was_return, out_was_call, out_pushed, out_was_indirect, out_dir_fix, 2'b0}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'(out_valid), 64'd0);

        for (int i = 0; i < 512; i++) begin
            in_valid   = 1'b1;
            {is_uncond, is_call, is_return, is_direct, dir_taken,
             btb_hit, ind_enable, ind_hit, stk_empty} = 9'(i);
            in_pc      = 32'h0040_0000 + 32'(i) * 32'd12;
            btb_target = 32'h1000_0000 ^ (32'(i) << 4);
            ind_target = 32'h2000_0100 + 32'(i) * 32'd8;
            stk_top    = 32'h3000_0000 + 32'(i) * 32'd16;
            model();
            @(negedge clk);
            compare();
            if (i % 97 == 5) begin
                // R2: gap cycle clears valid and commands
                in_valid = 1'b0;
                @(negedge clk);
                check("R2 gap valid", 64'(out_valid), 64'd0);
                check("R2 gap cmds", {62'd0, out_push, out_pop}, 64'd0);
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        check("R2 drain", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule